// File: doc/BRIEF.md
# Parallel Port Extended-Mode Negotiation Controller

This block is the host-side sequencer that takes a bidirectional parallel port out of compatibility mode into an extended transfer mode, and brings it back. A negotiate request carries an 8-bit mode code. The controller puts that code on the data lines and steps the four host control lines through the numbered handshake events. It watches the five peripheral status lines and ends with one of four results: success, timeout, I/O error or mode not supported.

A terminate request runs the handshake that returns the port to compatibility. Every wait is measured in ticks of a slow time base. The `tick` input is a one-cycle enable from an external prescaler. The setup and response limits are parameters. Data transfer phases are outside this block.

Top module: `lpt_neg_ctrl`

## Requirements
- R1: After reset, and while idle after a termination, the host lines are strobe_n=1, autofd_n=1, init_n=1, selectin_n=0. After reset the data lines are 0, status is 0 and mode is 0 (compatibility). init_n stays 1 at all times.
- R2: A negotiate request that arrives while selectin_n is already 1 is refused. On the next cycle done pulses with status 2 (I/O error), and the lines and mode do not change.
- R3: An accepted negotiate request puts the code on data_o at the next edge. The control lines stay unchanged until SETUP_TICKS ticks have passed. data_o keeps its value for the whole sequence.
- R4: When the setup time ends, the lines become selectin_n=1 and autofd_n=0, with strobe_n=1 and init_n=1.
- R5: The block then waits for perror=1, select=1, fault_n=1 and ack_n=0. If this pattern does not appear within RESP_TICKS ticks, done pulses with status 1 (timeout) and mode does not change.
- R6: Once the response is seen, strobe_n goes to 0 for SETUP_TICKS ticks. Then strobe_n and autofd_n both go to 1.
- R7: After that, ack_n must become 1 within SETUP_TICKS+RESP_TICKS ticks. Otherwise done pulses with status 2 (I/O error).
- R8: If the code is 0x00 (nibble), the request succeeds once ack_n is 1, whatever the level of select. done pulses with status 0 and mode 1.
- R9: For any nonzero code, select=1 at the moment ack_n is seen high gives status 0 and mode 2 (extended). select=0 gives status 3 (not supported) and mode does not change.
- R10: A terminate request drives selectin_n=0, autofd_n=1 and strobe_n=1. It waits for busy=1 and fault_n=1, then drives autofd_n=0. It then waits for ack_n=1, raises autofd_n and finishes with status 0. Each wait is limited to RESP_TICKS ticks.
- R11: A termination leaves mode at 0 even when it ends with status 1 (timeout). If the last wait times out, autofd_n is also returned to 1.
- R12: done is high only on the cycle a sequence finishes. status and mode hold their values until the next completion.
- R13: Negotiate and terminate requests that arrive while a sequence is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base enable from the prescaler |
| neg_req | input | 1 | Start negotiation (one cycle) |
| neg_code | input | 8 | Extensibility code to request |
| term_req | input | 1 | Start termination (one cycle) |
| ack_n | input | 1 | Peripheral acknowledge line level |
| busy | input | 1 | Peripheral busy line level |
| perror | input | 1 | Peripheral paper-error line level |
| select | input | 1 | Peripheral select line level |
| fault_n | input | 1 | Peripheral fault line level |
| data_o | output | 8 | Host data lines |
| strobe_n | output | 1 | Host strobe line level |
| autofd_n | output | 1 | Host auto-feed line level |
| init_n | output | 1 | Host init line level |
| selectin_n | output | 1 | Host select-in line level |
| done | output | 1 | Sequence completed (one cycle) |
| status | output | 2 | 0 ok, 1 timeout, 2 I/O error, 3 not supported |
| mode | output | 2 | 0 compatibility, 1 nibble, 2 extended |

## Verification
The assertions assume three things about the inputs. Requests are only pulsed at the bench's discretion. The peripheral lines change only between clock edges. `tick` never stays high for long runs, so the tick counters move at the prescaled rate. The stimulus keeps to this as follows. It drives every input on the falling edge. It leaves several idle cycles between requests. Its peripheral responds only from the host line levels it sees, so status-line changes follow the host's own steps.

// File: rtl/lpt_neg_pkg.sv
package lpt_neg_pkg;

    localparam int unsigned NLINES = 5;
    // status line vector positions
    localparam int unsigned L_ACKN  = 0;
    localparam int unsigned L_BUSY  = 1;
    localparam int unsigned L_PERR  = 2;
    localparam int unsigned L_SEL   = 3;
    localparam int unsigned L_FLTN  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_W_RESP,
        ST_LATCH,
        ST_W_ACK,
        ST_T_REQ,
        ST_T_ACK
    } neg_state_e;

    typedef enum logic [1:0] {
        STS_OK    = 2'd0,
        STS_TMO   = 2'd1,
        STS_IOERR = 2'd2,
        STS_UNSUP = 2'd3
    } neg_status_e;

    typedef enum logic [1:0] {
        MD_COMPAT = 2'd0,
        MD_NIBBLE = 2'd1,
        MD_EXT    = 2'd2
    } port_mode_e;

    typedef struct packed {
        neg_state_e  state;
        logic [7:0]  code;
        logic [7:0]  data;
        logic        strobe_n;
        logic        autofd_n;
        logic        init_n;
        logic        selectin_n;
        logic        done;
        neg_status_e status;
        port_mode_e  mode;
    } neg_regs_t;

endpackage

// File: rtl/lpt_line_match.sv
module lpt_line_match #(
    parameter int unsigned N = 5
) (
    input  logic [N-1:0] lines_i,
    input  logic [N-1:0] need_hi_i,
    input  logic [N-1:0] need_lo_i,
    output logic         met_o
);
    logic [N-1:0] bit_ok;

    for (genvar g = 0; g < N; g++) begin : g_bit
        assign bit_ok[g] = (!need_hi_i[g] || lines_i[g]) && (!need_lo_i[g] || !lines_i[g]);
    end

    assign met_o = &bit_ok;
endmodule

// File: rtl/lpt_tick_timer.sv
module lpt_tick_timer #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         tick_i,
    input  logic [W-1:0] limit_i,
    output logic         expire_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)     cnt_d = '0;
        else if (tick_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire_o = tick_i && (cnt_q == limit_i - 1'b1);

    // R5 R7 R10: a wait never counts past its own limit
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < limit_i);
endmodule

// File: rtl/lpt_neg_ctrl.sv
module lpt_neg_ctrl
    import lpt_neg_pkg::*;
#(
    parameter int unsigned SETUP_TICKS = 1,
    parameter int unsigned RESP_TICKS  = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       neg_req,
    input  logic [7:0] neg_code,
    input  logic       term_req,
    input  logic       ack_n,
    input  logic       busy,
    input  logic       perror,
    input  logic       select,
    input  logic       fault_n,
    output logic [7:0] data_o,
    output logic       strobe_n,
    output logic       autofd_n,
    output logic       init_n,
    output logic       selectin_n,
    output logic       done,
    output logic [1:0] status,
    output logic [1:0] mode
);
    localparam int unsigned LONG_TICKS = SETUP_TICKS + RESP_TICKS;
    localparam int unsigned CNT_W      = $clog2(LONG_TICKS + 1);

    neg_regs_t r_d, r_q;

    logic [NLINES-1:0] lines;
    logic [NLINES-1:0] need_hi, need_lo;
    logic              lines_met;
    logic [CNT_W-1:0]  limit;
    logic              tmr_clr, tmr_exp;

    assign lines[L_ACKN] = ack_n;
    assign lines[L_BUSY] = busy;
    assign lines[L_PERR] = perror;
    assign lines[L_SEL]  = select;
    assign lines[L_FLTN] = fault_n;

    lpt_line_match #(.N(NLINES)) u_match (
        .lines_i   (lines),
        .need_hi_i (need_hi),
        .need_lo_i (need_lo),
        .met_o     (lines_met)
    );

    lpt_tick_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (tmr_clr),
        .tick_i   (tick),
        .limit_i  (limit),
        .expire_o (tmr_exp)
    );

    // wait conditions and time limits per state
    always_comb begin
        need_hi = '0;
        need_lo = '0;
        limit   = CNT_W'(RESP_TICKS);
        case (r_q.state)
            ST_SETUP, ST_LATCH: limit = CNT_W'(SETUP_TICKS);
            ST_W_RESP: begin
                need_hi[L_PERR] = 1'b1;
                need_hi[L_SEL]  = 1'b1;
                need_hi[L_FLTN] = 1'b1;
                need_lo[L_ACKN] = 1'b1;
            end
            ST_W_ACK: begin
                need_hi[L_ACKN] = 1'b1;
                limit = CNT_W'(LONG_TICKS);
            end
            ST_T_REQ: begin
                need_hi[L_BUSY] = 1'b1;
                need_hi[L_FLTN] = 1'b1;
            end
            ST_T_ACK: need_hi[L_ACKN] = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (neg_req) begin
                    if (r_q.selectin_n) begin
                        r_d.done   = 1'b1;
                        r_d.status = STS_IOERR;
                    end else begin
                        r_d.code  = neg_code;
                        r_d.data  = neg_code;
                        r_d.state = ST_SETUP;
                    end
                end else if (term_req) begin
                    r_d.selectin_n = 1'b0;
                    r_d.autofd_n   = 1'b1;
                    r_d.strobe_n   = 1'b1;
                    r_d.init_n     = 1'b1;
                    r_d.state      = ST_T_REQ;
                end
            end
            ST_SETUP: begin
                if (tmr_exp) begin
                    r_d.selectin_n = 1'b1;
                    r_d.autofd_n   = 1'b0;
                    r_d.strobe_n   = 1'b1;
                    r_d.init_n     = 1'b1;
                    r_d.state      = ST_W_RESP;
                end
            end
            ST_W_RESP: begin
                if (lines_met) begin
                    r_d.strobe_n = 1'b0;
                    r_d.state    = ST_LATCH;
                end else if (tmr_exp) begin
                    r_d.done   = 1'b1;
                    r_d.status = STS_TMO;
                    r_d.state  = ST_IDLE;
                end
            end
            ST_LATCH: begin
                if (tmr_exp) begin
                    r_d.strobe_n = 1'b1;
                    r_d.autofd_n = 1'b1;
                    r_d.state    = ST_W_ACK;
                end
            end
            ST_W_ACK: begin
                if (lines_met) begin
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                    if (r_q.code == 8'h00) begin
                        r_d.status = STS_OK;
                        r_d.mode   = MD_NIBBLE;
                    end else if (select) begin
                        r_d.status = STS_OK;
                        r_d.mode   = MD_EXT;
                    end else begin
                        r_d.status = STS_UNSUP;
                    end
                end else if (tmr_exp) begin
                    r_d.done   = 1'b1;
                    r_d.status = STS_IOERR;
                    r_d.state  = ST_IDLE;
                end
            end
            ST_T_REQ: begin
                if (lines_met) begin
                    r_d.autofd_n = 1'b0;
                    r_d.state    = ST_T_ACK;
                end else if (tmr_exp) begin
                    r_d.done   = 1'b1;
                    r_d.status = STS_TMO;
                    r_d.mode   = MD_COMPAT;
                    r_d.state  = ST_IDLE;
                end
            end
            ST_T_ACK: begin
                if (lines_met || tmr_exp) begin
                    r_d.autofd_n = 1'b1;
                    r_d.done     = 1'b1;
                    r_d.status   = lines_met ? STS_OK : STS_TMO;
                    r_d.mode     = MD_COMPAT;
                    r_d.state    = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
        tmr_clr = (r_d.state != r_q.state) || (r_q.state == ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q            <= '0;
            r_q.state      <= ST_IDLE;
            r_q.strobe_n   <= 1'b1;
            r_q.autofd_n   <= 1'b1;
            r_q.init_n     <= 1'b1;
            r_q.selectin_n <= 1'b0;
            r_q.status     <= STS_OK;
            r_q.mode       <= MD_COMPAT;
        end else begin
            r_q <= r_d;
        end
    end

    assign data_o     = r_q.data;
    assign strobe_n   = r_q.strobe_n;
    assign autofd_n   = r_q.autofd_n;
    assign init_n     = r_q.init_n;
    assign selectin_n = r_q.selectin_n;
    assign done       = r_q.done;
    assign status     = r_q.status;
    assign mode       = r_q.mode;

    // R2: refusal when selectin_n already high
    p_refuse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && neg_req && selectin_n) |=> (done && status == STS_IOERR));
    // R3: data lines hold during a sequence
    p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_IDLE) |=> $stable(data_o));
    // R4: line pattern while waiting for the peripheral response
    p_ev1_lines_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_W_RESP) |-> (selectin_n && !autofd_n && strobe_n && init_n));
    // R6: strobe and auto-feed both return high after the latch phase
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_LATCH && tmr_exp) |=> (strobe_n && autofd_n));
    // R8: nibble code accepted regardless of select
    p_nibble_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_W_ACK && ack_n && r_q.code == 8'h00) |=> (status == STS_OK && mode == MD_NIBBLE));
    // R11: termination always ends in compatibility mode
    p_term_compat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.state == ST_T_REQ || r_q.state == ST_T_ACK) && r_d.state == ST_IDLE) |=> (mode == MD_COMPAT && autofd_n));
    // R12: completion only reported from idle
    p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (r_q.state == ST_IDLE));
endmodule

// File: tb/lpt_neg_ctrl_tb.sv
module lpt_neg_ctrl_tb;
    localparam int SU = 2;
    localparam int RS = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic neg_req = 1'b0;
    logic [7:0] neg_code = 8'h00;
    logic term_req = 1'b0;
    logic ack_n = 1'b1, busy = 1'b0, perror = 1'b0, select = 1'b1, fault_n = 1'b1;
    logic [7:0] data_o;
    logic strobe_n, autofd_n, init_n, selectin_n, done;
    logic [1:0] status, mode;

    always #5 clk = ~clk;

    lpt_neg_ctrl #(.SETUP_TICKS(SU), .RESP_TICKS(RS)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .neg_req(neg_req), .neg_code(neg_code), .term_req(term_req),
        .ack_n(ack_n), .busy(busy), .perror(perror), .select(select), .fault_n(fault_n),
        .data_o(data_o), .strobe_n(strobe_n), .autofd_n(autofd_n), .init_n(init_n),
        .selectin_n(selectin_n), .done(done), .status(status), .mode(mode)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    // peripheral behaviour knobs
    bit k_resp = 1, k_ack = 1, k_sel = 1, k_tbusy = 1, k_tack = 1;

    // reference model state
    int m_ph, m_tk;
    logic m_sel, m_af, m_stb, m_done;
    logic [7:0] m_data, m_code;
    int m_st, m_mode;

    task automatic chk(input string req, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph <= 0; m_tk <= 0;
            m_sel <= 0; m_af <= 1; m_stb <= 1; m_done <= 0;
            m_data <= 0; m_code <= 0; m_st <= 0; m_mode <= 0;
        end else begin
            m_done <= 0;
            if (m_ph == 0) begin
                if (neg_req) begin
                    if (m_sel) begin m_done <= 1; m_st <= 2; end
                    else begin m_data <= neg_code; m_code <= neg_code; m_ph <= 1; m_tk <= 0; end
                end else if (term_req) begin
                    m_sel <= 0; m_af <= 1; m_stb <= 1; m_ph <= 5; m_tk <= 0;
                end
            end else if (m_ph == 1) begin
                if (tick) begin
                    if (m_tk + 1 == SU) begin m_sel <= 1; m_af <= 0; m_stb <= 1; m_ph <= 2; m_tk <= 0; end
                    else m_tk <= m_tk + 1;
                end
            end else if (m_ph == 2) begin
                if (!ack_n && perror && select && fault_n) begin m_stb <= 0; m_ph <= 3; m_tk <= 0; end
                else if (tick) begin
                    if (m_tk + 1 == RS) begin m_done <= 1; m_st <= 1; m_ph <= 0; end
                    else m_tk <= m_tk + 1;
                end
            end else if (m_ph == 3) begin
                if (tick) begin
                    if (m_tk + 1 == SU) begin m_stb <= 1; m_af <= 1; m_ph <= 4; m_tk <= 0; end
                    else m_tk <= m_tk + 1;
                end
            end else if (m_ph == 4) begin
                if (ack_n) begin
                    m_done <= 1; m_ph <= 0;
                    if (m_code == 8'h00) begin m_st <= 0; m_mode <= 1; end
                    else if (select) begin m_st <= 0; m_mode <= 2; end
                    else m_st <= 3;
                end else if (tick) begin
                    if (m_tk + 1 == SU + RS) begin m_done <= 1; m_st <= 2; m_ph <= 0; end
                    else m_tk <= m_tk + 1;
                end
            end else if (m_ph == 5) begin
                if (busy && fault_n) begin m_af <= 0; m_ph <= 6; m_tk <= 0; end
                else if (tick) begin
                    if (m_tk + 1 == RS) begin m_done <= 1; m_st <= 1; m_mode <= 0; m_ph <= 0; end
                    else m_tk <= m_tk + 1;
                end
            end else begin
                if (ack_n) begin m_af <= 1; m_done <= 1; m_st <= 0; m_mode <= 0; m_ph <= 0; end
                else if (tick) begin
                    if (m_tk + 1 == RS) begin m_af <= 1; m_done <= 1; m_st <= 1; m_mode <= 0; m_ph <= 0; end
                    else m_tk <= m_tk + 1;
                end
            end
        end
    end

    // falling edge: compare, then drive tick and the peripheral
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !finished) begin
            chk("R3", data_o, m_data, "data lines");
            chk("R4", selectin_n, m_sel, "selectin_n");
            chk("R10", autofd_n, m_af, "autofd_n");
            chk("R6", strobe_n, m_stb, "strobe_n");
            chk("R1", init_n, 1, "init_n");
            chk("R12", done, m_done, "done");
            chk("R12", status, m_st, "status");
            chk("R9", mode, m_mode, "mode");
        end
        tick = (cyc % 3 == 0);
        if (selectin_n && !autofd_n) begin
            if (k_resp) begin ack_n = 0; perror = 1; select = 1; fault_n = 1; busy = 0; end
            else begin ack_n = 1; perror = 0; select = 1; fault_n = 1; busy = 0; end
        end else if (selectin_n && autofd_n) begin
            ack_n = k_ack; select = k_sel; perror = 1; fault_n = 1; busy = 0;
        end else if (!selectin_n && autofd_n) begin
            ack_n = 0; busy = k_tbusy; fault_n = 1; perror = 0; select = 1;
        end else begin
            ack_n = k_tack; busy = 1; fault_n = 1;
        end
        if (cyc > 100000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic gap();
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 400) begin @(negedge clk); n++; end
    endtask

    task automatic do_neg(input logic [7:0] c, input bit poke_term);
        @(negedge clk);
        neg_req = 1; neg_code = c;
        @(negedge clk);
        neg_req = 0;
        if (poke_term) begin term_req = 1; @(negedge clk); term_req = 0; end
        wait_done();
    endtask

    task automatic do_term();
        @(negedge clk);
        term_req = 1;
        @(negedge clk);
        term_req = 0;
        wait_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", {strobe_n, autofd_n, init_n, selectin_n}, 4'b1110, "idle lines");
        chk("R1", mode, 0, "reset mode");
        chk("R1", done, 0, "reset done");

        // R8 nibble succeeds with select low; R13 term request ignored mid-run
        k_resp = 1; k_ack = 1; k_sel = 0;
        do_neg(8'h00, 1'b1);
        chk("R8", status, 0, "nibble status");
        chk("R8", mode, 1, "nibble mode");
        chk("R13", selectin_n, 1, "term ignored, still negotiated");
        gap();

        // R2 refused while selectin_n high
        do_neg(8'h30, 1'b0);
        chk("R2", status, 2, "refuse status");
        chk("R2", mode, 1, "refuse mode kept");
        chk("R2", selectin_n, 1, "refuse lines kept");
        gap();

        // R10 full termination
        k_tbusy = 1; k_tack = 1;
        do_term();
        chk("R10", status, 0, "term status");
        chk("R10", mode, 0, "term mode");
        @(negedge clk);
        chk("R1", {strobe_n, autofd_n, init_n, selectin_n}, 4'b1110, "idle after term");
        gap();

        // R9 extended accepted
        k_sel = 1;
        do_neg(8'h30, 1'b0);
        chk("R3", data_o, 8'h30, "code on data");
        chk("R9", status, 0, "ext status");
        chk("R9", mode, 2, "ext mode");
        gap();

        // R11 termination timing out at the first wait
        k_tbusy = 0;
        do_term();
        chk("R11", status, 1, "term timeout status");
        chk("R11", mode, 0, "term timeout mode");
        gap();

        // R9 not supported
        k_sel = 0;
        do_neg(8'h5A, 1'b0);
        chk("R9", status, 3, "unsupported status");
        chk("R9", mode, 0, "unsupported mode");
        gap();
        k_tbusy = 1;
        do_term();
        gap();

        // R5 no peripheral response
        k_resp = 0;
        do_neg(8'h10, 1'b0);
        chk("R5", status, 1, "response timeout");
        chk("R5", mode, 0, "mode after timeout");
        gap();
        do_term();
        gap();

        // R7 nAck never returns high
        k_resp = 1; k_ack = 0;
        do_neg(8'h30, 1'b0);
        chk("R7", status, 2, "ack timeout io error");
        gap();

        // R11 termination timing out at the second wait
        k_tack = 0;
        do_term();
        chk("R11", status, 1, "late term timeout");
        chk("R11", mode, 0, "late term mode");
        chk("R11", autofd_n, 1, "autofd restored");
        gap();

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule